// File: doc/BRIEF.md
# Idle-Cycle ALU Online Tester

This block checks a 32-bit ALU for silicon defects while the pipeline keeps running. Whenever the pipeline reports that the ALU has no real work in a cycle, the block raises its test-mode output. The operand and opcode multiplexers then feed the ALU from a small built-in store of test vectors instead of from the forwarded pipeline operands. The ALU result comes back into the block, which recomputes it on a narrow 9-bit checker ALU. Each cycle covers one byte slice together with its carry, so one 32-bit result is verified over four idle cycles.

Real operations always win. On a busy cycle the multiplexers pass the pipeline operands through, and the tester freezes its slice position, vector position and slice carry until the next idle cycle. Any slice mismatch sets a sticky fault flag, which stays set until it is cleared from outside. A one-cycle done pulse marks each full pass over all vectors in which no mismatch was seen. After that the vector store starts again from its first entry.

Top module: `alu_idle_tester`

## Requirements
- R1: `test_mode` follows `alu_idle` in the same cycle. While `test_mode` is 0, `alu_a`, `alu_b` and `alu_op` equal `pipe_a`, `pipe_b` and `pipe_op`.
- R2: In test mode, one stored vector drives the ALU for 4 idle cycles with unchanged operands. The opcode of vector i is i mod 5, encoded add=0, sub=1, and=2, or=3, xor=4.
- R3: A pass covers 20 vectors (80 idle cycles). After the last vector the store returns to vector 0, so the opcode sequence repeats.
- R4: Each idle cycle checks exactly one 8-bit slice of the ALU result, from the least significant slice (bits 7:0) to the most significant (bits 31:24). A corrupted bit outside the slice under check in that cycle is not flagged.
- R5: Carries pass from one slice to the next, and subtract starts with a carry-in of 1. A correct ALU is never flagged, including on vectors whose carries run through all four slices.
- R6: A slice mismatch sets `fault` at the next clock edge. `fault` then stays 1 while `clr_fault` is low.
- R7: `clr_fault` clears `fault` at the next edge. If a mismatch happens in the same cycle as the clear, the flag stays set.
- R8: A busy cycle (`alu_idle` = 0) compares nothing and keeps the slice position, vector position and carry. Checking resumes at the same point on the next idle cycle.
- R9: `done` is a one-cycle pulse that follows the edge closing the last slice of vector 19, and it appears only if no slice of that pass mismatched.
- R10: After reset `fault` and `done` are 0 and the tester starts at vector 0, slice 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_idle | input | 1 | Pipeline has no ALU operation this cycle |
| pipe_a | input | 32 | Forwarded pipeline operand A |
| pipe_b | input | 32 | Forwarded pipeline operand B |
| pipe_op | input | 3 | Pipeline ALU opcode |
| clr_fault | input | 1 | Clears the sticky fault flag |
| alu_y | input | 32 | Result returned by the ALU under test |
| test_mode | output | 1 | Operand multiplexer select, 1 = test vectors |
| alu_a | output | 32 | Operand A to the ALU |
| alu_b | output | 32 | Operand B to the ALU |
| alu_op | output | 3 | Opcode to the ALU |
| fault | output | 1 | Sticky defect flag |
| done | output | 1 | Clean-pass pulse |

## Verification
The bench builds the block with its defaults: 32-bit width, 8-bit slices and 20 vectors. At that size one pass is only 80 idle cycles, so every pairing of vector and slice can be visited. The bench corrupts each of the 80 (vector, slice) positions in turn, once inside the slice under check and once in a neighbouring byte. The reference ALU result is computed arithmetically in the bench from the operands the block drives, which covers every carry chain in the store. Busy cycles are interleaved in a pseudo-random pattern so that resumption and the done count are tested under interruption.

// File: rtl/alu_idle_tester.sv
module alu_idle_tester #(
  parameter int WIDTH = 32,
  parameter int SLICE = 8,
  parameter int NVEC  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alu_idle,
  input  logic [WIDTH-1:0] pipe_a,
  input  logic [WIDTH-1:0] pipe_b,
  input  logic [2:0]       pipe_op,
  input  logic             clr_fault,
  input  logic [WIDTH-1:0] alu_y,
  output logic             test_mode,
  output logic [WIDTH-1:0] alu_a,
  output logic [WIDTH-1:0] alu_b,
  output logic [2:0]       alu_op,
  output logic             fault,
  output logic             done
);
  localparam int NSL = WIDTH / SLICE;
  localparam int SW  = (NSL > 1) ? $clog2(NSL) : 1;
  localparam int VW  = (NVEC > 1) ? $clog2(NVEC) : 1;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_AND = 3'd2;
  localparam logic [2:0] OP_OR  = 3'd3;
  localparam logic [2:0] OP_XOR = 3'd4;

  function automatic logic [WIDTH-1:0] gen_a(input logic [VW-1:0] i);
    logic [31:0] s;
    s = (32'(i) + 32'd1) * 32'h9E37_79B9;
    if (32'(i) < 32'd5) return '1;
    return WIDTH'(s ^ {s[15:0], s[31:16]});
  endfunction

  function automatic logic [WIDTH-1:0] gen_b(input logic [VW-1:0] i);
    logic [31:0] s;
    s = 32'h7F4A_7C15 ^ (32'd1 << (32'(i) % 32)) ^ (32'(i) * 32'h0101_0101);
    if (32'(i) < 32'd5) return WIDTH'(1);
    return WIDTH'(s);
  endfunction

  function automatic logic [2:0] gen_op(input logic [VW-1:0] i);
    return 3'(32'(i) % 32'd5);
  endfunction

  logic [SW-1:0]    slice_q;
  logic [VW-1:0]    vec_q;
  logic             carry_q;
  logic             fault_q;
  logic             bad_q;
  logic             done_q;

  logic [WIDTH-1:0] cur_a, cur_b;
  logic [2:0]       cur_op;
  logic [SLICE-1:0] a_s, b_s, y_s;
  logic [SLICE:0]   mini;
  logic             cin, mismatch, last_slice, last_vec;

  assign cur_a  = gen_a(vec_q);
  assign cur_b  = gen_b(vec_q);
  assign cur_op = gen_op(vec_q);

  assign test_mode = alu_idle;
  assign alu_a  = test_mode ? cur_a  : pipe_a;
  assign alu_b  = test_mode ? cur_b  : pipe_b;
  assign alu_op = test_mode ? cur_op : pipe_op;

  assign a_s = cur_a[slice_q*SLICE +: SLICE];
  assign b_s = cur_b[slice_q*SLICE +: SLICE];
  assign y_s = alu_y[slice_q*SLICE +: SLICE];
  assign cin = (slice_q == '0) ? (cur_op == OP_SUB) : carry_q;

  always_comb begin
    case (cur_op)
      OP_ADD:  mini = {1'b0, a_s} + {1'b0, b_s} + {{SLICE{1'b0}}, cin};
      OP_SUB:  mini = {1'b0, a_s} + {1'b0, ~b_s} + {{SLICE{1'b0}}, cin};
      OP_AND:  mini = {1'b0, a_s & b_s};
      OP_OR:   mini = {1'b0, a_s | b_s};
      OP_XOR:  mini = {1'b0, a_s ^ b_s};
      default: mini = '0;
    endcase
  end

  assign mismatch   = alu_idle && (mini[SLICE-1:0] != y_s);
  assign last_slice = (slice_q == SW'(NSL - 1));
  assign last_vec   = (vec_q == VW'(NVEC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slice_q <= '0;
      vec_q   <= '0;
      carry_q <= 1'b0;
      fault_q <= 1'b0;
      bad_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (mismatch)       fault_q <= 1'b1;
      else if (clr_fault) fault_q <= 1'b0;
      if (alu_idle) begin
        carry_q <= mini[SLICE];
        if (last_slice) begin
          slice_q <= '0;
          if (last_vec) begin
            vec_q  <= '0;
            bad_q  <= 1'b0;
            done_q <= !(bad_q || mismatch);
          end else begin
            vec_q <= vec_q + 1'b1;
            bad_q <= bad_q || mismatch;
          end
        end else begin
          slice_q <= slice_q + 1'b1;
          bad_q   <= bad_q || mismatch;
        end
      end
    end
  end

  assign fault = fault_q;
  assign done  = done_q;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_idle |=> $stable(slice_q) && $stable(vec_q) && $stable(carry_q));
  assert_detect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> fault);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !clr_fault |=> fault);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fault && !mismatch |=> !fault);
  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> vec_q == '0 && slice_q == '0);
  assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(vec_q) < NVEC);
endmodule

// File: tb/tb_alu_idle_tester.sv
module tb_alu_idle_tester;
  localparam int W = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alu_idle = 1'b0;
  logic [W-1:0] pipe_a = '0, pipe_b = '0;
  logic [2:0] pipe_op = '0;
  logic clr_fault = 1'b0;
  logic [W-1:0] alu_y, ref_y, inj_mask = '0;
  logic test_mode, fault, done;
  logic [W-1:0] alu_a, alu_b;
  logic [2:0] alu_op;

  int checks = 0, errors = 0, n = 0, cyc = 0;
  logic [31:0] lfsr = 32'hACE1_2345;

  always #4 clk = ~clk;

  alu_idle_tester dut (
    .clk(clk), .rst_n(rst_n), .alu_idle(alu_idle), .pipe_a(pipe_a), .pipe_b(pipe_b),
    .pipe_op(pipe_op), .clr_fault(clr_fault), .alu_y(alu_y), .test_mode(test_mode),
    .alu_a(alu_a), .alu_b(alu_b), .alu_op(alu_op), .fault(fault), .done(done)
  );

  always_comb begin
    case (alu_op)
      3'd0: ref_y = alu_a + alu_b;
      3'd1: ref_y = alu_a - alu_b;
      3'd2: ref_y = alu_a & alu_b;
      3'd3: ref_y = alu_a | alu_b;
      3'd4: ref_y = alu_a ^ alu_b;
      default: ref_y = alu_b;
    endcase
  end
  assign alu_y = ref_y ^ inj_mask;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic idle, input logic clr, input logic [W-1:0] mask);
    @(negedge clk);
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    alu_idle = idle;
    clr_fault = clr;
    inj_mask = mask;
    pipe_a = lfsr;
    pipe_b = {lfsr[15:0], lfsr[31:16]};
    pipe_op = 3'(lfsr[2:0] % 5);
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    if (alu_idle) n = n + 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; alu_idle = 1'b0; clr_fault = 1'b0; inj_mask = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
  endtask

  initial begin
    logic [W-1:0] prev_a, prev_b;
    int dones, seen_fault;
    do_reset();
    chk(fault == 1'b0, "R10 fault after reset", 64'(fault), 0);
    chk(done == 1'b0, "R10 done after reset", 64'(done), 0);
    chk(test_mode == 1'b0, "R1 test_mode low when busy", 64'(test_mode), 0);

    // clean continuous run over two passes
    prev_a = '0; prev_b = '0;
    for (int c = 0; c < 164; c++) begin
      drive(1'b1, 1'b0, '0);
      chk(test_mode == 1'b1, "R1 test_mode follows idle", 64'(test_mode), 1);
      chk(alu_op == 3'(((n / 4) % 20) % 5), "R2 R3 vector opcode", 64'(alu_op), 64'(((n / 4) % 20) % 5));
      if (n % 4 != 0)
        chk(alu_a == prev_a && alu_b == prev_b, "R2 operands held over slices", 64'(alu_a), 64'(prev_a));
      prev_a = alu_a; prev_b = alu_b;
      tick();
      chk(done == ((n % 80) == 0), "R9 R3 done at pass end", 64'(done), 64'((n % 80) == 0));
      chk(fault == 1'b0, "R5 no false alarm with carries", 64'(fault), 0);
    end

    // busy cycles: pass-through and no checking
    for (int c = 0; c < 12; c++) begin
      drive(1'b0, 1'b0, '1);
      chk(alu_a == pipe_a && alu_b == pipe_b && alu_op == pipe_op, "R1 pass-through",
          64'(alu_a), 64'(pipe_a));
      chk(test_mode == 1'b0, "R1 test_mode low", 64'(test_mode), 0);
      tick();
      chk(fault == 1'b0, "R8 busy cycle not compared", 64'(fault), 0);
    end

    // detection sweep over every vector and slice
    for (int v = 0; v < 20; v++) begin
      for (int k = 0; k < 4; k++) begin
        do_reset();
        dones = 0;
        for (int c = 0; c < 81; c++) begin
          if (n == v * 4 + k) begin
            chk(fault == 1'b0, "R6 fault clear before defect", 64'(fault), 0);
            drive(1'b1, 1'b0, W'(1) << (8 * k + (v % 8)));
          end else drive(1'b1, 1'b0, '0);
          tick();
          if (done) dones++;
          if (n == v * 4 + k + 1)
            chk(fault == 1'b1, $sformatf("R6 R4 detect v%0d s%0d", v, k), 64'(fault), 1);
        end
        chk(fault == 1'b1, "R6 sticky to end of pass", 64'(fault), 1);
        chk(dones == 0, "R9 no done on faulty pass", 64'(dones), 0);
      end
    end

    // corruption outside the slice under check is ignored
    for (int v = 0; v < 20; v++) begin
      for (int k = 0; k < 4; k++) begin
        do_reset();
        while (n <= v * 4 + k) begin
          if (n == v * 4 + k) drive(1'b1, 1'b0, W'(1) << (8 * ((k + 1) % 4) + 3));
          else drive(1'b1, 1'b0, '0);
          tick();
        end
        chk(fault == 1'b0, $sformatf("R4 other byte ignored v%0d s%0d", v, k), 64'(fault), 0);
      end
    end

    // interrupted clean run
    do_reset();
    dones = 0;
    while (n < 160) begin
      if (lfsr[3] & lfsr[9]) drive(1'b0, 1'b0, '1);
      else drive(1'b1, 1'b0, '0);
      tick();
      if (done) dones++;
    end
    chk(dones == 2, "R8 two clean passes with interruptions", 64'(dones), 2);
    chk(fault == 1'b0, "R8 no fault across interruptions", 64'(fault), 0);

    // interrupted run with defect at vector 7 slice 2
    do_reset();
    seen_fault = 0;
    while (n < 40) begin
      if (lfsr[4] & lfsr[11]) drive(1'b0, 1'b0, '0);
      else if (n == 30) drive(1'b1, 1'b0, W'(1) << 21);
      else drive(1'b1, 1'b0, '0);
      tick();
      if (fault && seen_fault == 0) begin
        seen_fault = 1;
        chk(n == 31, "R8 resumed slice detects defect", 64'(n), 31);
      end
    end
    chk(seen_fault == 1, "R8 defect found after interruptions", 64'(seen_fault), 1);

    // clear and set-wins
    drive(1'b0, 1'b1, '0);
    tick();
    chk(fault == 1'b0, "R7 clear", 64'(fault), 0);
    while (n % 4 != 0) begin drive(1'b1, 1'b0, '0); tick(); end
    drive(1'b1, 1'b0, W'(1));
    tick();
    chk(fault == 1'b1, "R6 set again", 64'(fault), 1);
    while (n % 4 != 0) begin drive(1'b1, 1'b0, '0); tick(); end
    drive(1'b1, 1'b1, W'(1));
    tick();
    chk(fault == 1'b1, "R7 set wins over clear", 64'(fault), 1);
    drive(1'b1, 1'b1, '0);
    tick();
    chk(fault == 1'b0, "R7 clear after set", 64'(fault), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule